// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits inside a small processor core and carries out the hardware part of taking an interrupt and of returning from one. It holds the program counter and the status word of the core. The core reports each completed instruction with a boundary strobe. At such a boundary, a level-sensitive device request is accepted only when the interrupt-enable bit of the status word is set. The sequencer then acknowledges the device and saves two words on a stack memory: the address of the next instruction, then the status word. After that it sends the program counter to a handler entry address that is set by a parameter.

A return command given at an instruction boundary reverses the sequence. It pops the status word, then the program counter, so the next fetch continues the interrupted program. While a push or pop sequence runs, a busy output stalls the core's fetch. Saving general-purpose registers is left to the handler software.

The stack memory is external. Its address port has an asynchronous read and is written on the clock edge when the push strobe is high. The stack grows downward: a push writes one word below the current stack pointer, and a pop reads the word at the pointer.

Top module: `intr_seq_top`

## Requirements
- R1: During and after synchronous reset the program counter is 0, the status word is 0, the stack address equals the top value STK_TOP, and busy, acknowledge, push and pop are all low.
- R2: When the sequencer is idle and an instruction boundary is taken without entry or return, the program counter advances by exactly 1 on that edge.
- R3: A request is accepted only on a cycle where the boundary strobe, the request and the interrupt-enable bit (status word bit 0) are all high. Otherwise no acknowledge and no push occur.
- R4: The acknowledge is a single-cycle pulse. It is high in the cycle after the accepting edge, which is also the first push cycle.
- R5: Entry pushes two words on two consecutive cycles. First comes N+1, where N is the address of the boundary instruction, at address STK_TOP-1. Then comes the status word at STK_TOP-2. The stack pointer drops by one per push.
- R6: When entry completes, the program counter equals HANDLER_PC and bit 0 of the status word is cleared while the other bits are kept. Later requests are then not taken.
- R7: A return command at an idle boundary first pops the status word from the stack pointer, then pops the program counter from the next address up. The pointer rises by one per pop, and both registers take the values that were saved.
- R8: Busy is high in every push and pop cycle. Boundary strobes, requests and status-word writes that arrive while busy is high have no effect.
- R9: When a return command and an accepted request arrive at the same boundary, the return wins and no acknowledge is issued.
- R10: While the sequencer is idle, a status-word write loads the whole status word on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_done | input | 1 | Instruction boundary strobe from the core |
| irq_req | input | 1 | Level-sensitive device interrupt request |
| rti_cmd | input | 1 | Return-from-interrupt command, valid with insn_done |
| sw_wr | input | 1 | Status word write strobe |
| sw_wdata | input | DW | Status word write value |
| irq_ack | output | 1 | Single-cycle acknowledge to the device |
| busy | output | 1 | Fetch stall while pushing or popping |
| pc | output | DW | Program counter |
| status_word | output | DW | Processor status word, bit 0 = interrupt enable |
| stk_push | output | 1 | Stack write strobe |
| stk_pop | output | 1 | Stack read strobe |
| stk_addr | output | SAW | Stack memory address |
| stk_wdata | output | DW | Stack write data |
| stk_rdata | input | DW | Stack read data, valid in the same cycle as stk_addr |

## Verification
The assertions assume three things about the inputs: the boundary strobe is a one-cycle event, the stack memory returns read data combinationally, and the return command only arrives with a boundary strobe. The stimulus drives the strobe for exactly one cycle, keeps the return command and status writes paired with idle boundaries except where the ignore-while-busy case is under test, and models the stack as an asynchronous-read array. Requests are dropped right after the acknowledge, as a well-behaved device would do. A request that is held high on purpose is used only to show that it is held off while interrupts are disabled.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

    localparam int unsigned IE_BIT = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PC,
        ST_PUSH_SW,
        ST_POP_SW,
        ST_POP_PC
    } seq_state_e;

    typedef struct packed {
        logic idle;
        logic step;
        logic take;
        logic push_pc;
        logic push_sw;
        logic pop_sw;
        logic pop_pc;
    } seq_ctl_t;

    function automatic logic is_push(input seq_ctl_t c);
        return c.push_pc | c.push_sw;
    endfunction

    function automatic logic is_pop(input seq_ctl_t c);
        return c.pop_sw | c.pop_pc;
    endfunction

endpackage

// File: rtl/intr_seq_fsm.sv
module intr_seq_fsm
    import intr_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     insn_done,
    input  logic     irq_req,
    input  logic     rti_cmd,
    input  logic     ie,
    output seq_ctl_t ctl,
    output logic     irq_ack,
    output logic     busy
);

    seq_state_e state, nxt;

    always_comb begin
        nxt = state;
        ctl = '0;
        ctl.idle = (state == ST_IDLE);
        unique case (state)
            ST_IDLE: begin
                if (insn_done) begin
                    if (rti_cmd) begin
                        nxt = ST_POP_SW;
                    end else if (irq_req && ie) begin
                        nxt = ST_PUSH_PC;
                        ctl.take = 1'b1;
                    end else begin
                        ctl.step = 1'b1;
                    end
                end
            end
            ST_PUSH_PC: begin
                ctl.push_pc = 1'b1;
                nxt = ST_PUSH_SW;
            end
            ST_PUSH_SW: begin
                ctl.push_sw = 1'b1;
                nxt = ST_IDLE;
            end
            ST_POP_SW: begin
                ctl.pop_sw = 1'b1;
                nxt = ST_POP_PC;
            end
            ST_POP_PC: begin
                ctl.pop_pc = 1'b1;
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign irq_ack = (state == ST_PUSH_PC);
    assign busy    = (state != ST_IDLE);

    // R4: acknowledge never lasts two cycles
    assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);

    // R3: acknowledge only follows a boundary with an enabled request
    assert_ack_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_ack) |-> $past(insn_done && irq_req && ie && !rti_cmd));

endmodule

// File: rtl/intr_stack_ptr.sv
module intr_stack_ptr #(
    parameter int unsigned SAW     = 8,
    parameter int unsigned STK_TOP = 255
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           push,
    input  logic           pop,
    output logic [SAW-1:0] addr
);

    localparam logic [SAW-1:0] TOP_VAL = STK_TOP[SAW-1:0];

    logic [SAW-1:0] sp;

    always_ff @(posedge clk) begin
        if (rst)       sp <= TOP_VAL;
        else if (push) sp <= sp - 1'b1;
        else if (pop)  sp <= sp + 1'b1;
    end

    assign addr = push ? (sp - 1'b1) : sp;

    // R8: a cycle either pushes or pops, never both
    assert_one_dir_R8: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));

    // R5: each push lowers the pointer by one word
    assert_sp_dec_R5: assert property (@(posedge clk) disable iff (rst)
        push |=> (sp == $past(sp) - 1'b1));

    // R7: each pop raises the pointer by one word
    assert_sp_inc_R7: assert property (@(posedge clk) disable iff (rst)
        pop |=> (sp == $past(sp) + 1'b1));

endmodule

// File: rtl/intr_arch_regs.sv
module intr_arch_regs
    import intr_seq_pkg::*;
#(
    parameter int unsigned   DW         = 16,
    parameter logic [DW-1:0] HANDLER_PC = 16'h0100
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_ctl_t      ctl,
    input  logic          sw_wr,
    input  logic [DW-1:0] sw_wdata,
    input  logic [DW-1:0] stk_rdata,
    output logic [DW-1:0] pc,
    output logic [DW-1:0] status_word,
    output logic [DW-1:0] stk_wdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc          <= '0;
            status_word <= '0;
        end else begin
            if (ctl.step || ctl.take) pc <= pc + 1'b1;
            if (ctl.push_sw) begin
                pc                  <= HANDLER_PC;
                status_word[IE_BIT] <= 1'b0;
            end
            if (ctl.pop_sw) status_word <= stk_rdata;
            if (ctl.pop_pc) pc <= stk_rdata;
            if (sw_wr && ctl.idle) status_word <= sw_wdata;
        end
    end

    assign stk_wdata = ctl.push_pc ? pc : status_word;

    // R6: entry ends at the handler with interrupts disabled
    assert_entry_R6: assert property (@(posedge clk) disable iff (rst)
        ctl.push_sw |=> (pc == HANDLER_PC && !status_word[IE_BIT]));

    // R7: the second pop lands the saved address in the PC
    assert_ret_pc_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.pop_pc |=> (pc == $past(stk_rdata)));

endmodule

// File: rtl/intr_seq_top.sv
module intr_seq_top
    import intr_seq_pkg::*;
#(
    parameter int unsigned   DW         = 16,
    parameter int unsigned   SAW        = 8,
    parameter int unsigned   STK_TOP    = 255,
    parameter logic [DW-1:0] HANDLER_PC = 16'h0100
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           insn_done,
    input  logic           irq_req,
    input  logic           rti_cmd,
    input  logic           sw_wr,
    input  logic [DW-1:0]  sw_wdata,
    output logic           irq_ack,
    output logic           busy,
    output logic [DW-1:0]  pc,
    output logic [DW-1:0]  status_word,
    output logic           stk_push,
    output logic           stk_pop,
    output logic [SAW-1:0] stk_addr,
    output logic [DW-1:0]  stk_wdata,
    input  logic [DW-1:0]  stk_rdata
);

    seq_ctl_t ctl;

    intr_seq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .insn_done (insn_done),
        .irq_req   (irq_req),
        .rti_cmd   (rti_cmd),
        .ie        (status_word[IE_BIT]),
        .ctl       (ctl),
        .irq_ack   (irq_ack),
        .busy      (busy)
    );

    assign stk_push = is_push(ctl);
    assign stk_pop  = is_pop(ctl);

    intr_stack_ptr #(.SAW(SAW), .STK_TOP(STK_TOP)) u_sp (
        .clk  (clk),
        .rst  (rst),
        .push (stk_push),
        .pop  (stk_pop),
        .addr (stk_addr)
    );

    intr_arch_regs #(.DW(DW), .HANDLER_PC(HANDLER_PC)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .sw_wr       (sw_wr),
        .sw_wdata    (sw_wdata),
        .stk_rdata   (stk_rdata),
        .pc          (pc),
        .status_word (status_word),
        .stk_wdata   (stk_wdata)
    );

    // R8: stack traffic only while the core is stalled
    assert_busy_stack_R8: assert property (@(posedge clk) disable iff (rst)
        (stk_push || stk_pop) |-> busy);

    // R5: the first word written on entry is the acknowledged return address
    assert_push_first_R5: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (stk_push && stk_wdata == pc));

endmodule

// File: tb/intr_seq_top_tb.sv
module intr_seq_top_tb_top;

    localparam int DW  = 16;
    localparam int SAW = 8;
    localparam int TOP = 255;
    localparam logic [DW-1:0] HPC = 16'h0100;

    localparam int NV = 4;
    localparam logic [7:0]    V_STEPS [NV] = '{8'd3, 8'd0, 8'd17, 8'd9};
    localparam logic [DW-1:0] V_SW    [NV] = '{16'h0001, 16'hA5A5, 16'h8003, 16'h7FFF};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic insn_done = 1'b0, irq_req = 1'b0, rti_cmd = 1'b0, sw_wr = 1'b0;
    logic [DW-1:0] sw_wdata = '0;
    logic irq_ack, busy, stk_push, stk_pop;
    logic [DW-1:0] pc, status_word, stk_wdata, stk_rdata;
    logic [SAW-1:0] stk_addr;
    logic [DW-1:0] mem [2**SAW];

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    intr_seq_top #(.DW(DW), .SAW(SAW), .STK_TOP(TOP), .HANDLER_PC(HPC)) dut_i (
        .clk(clk), .rst(rst), .insn_done(insn_done), .irq_req(irq_req),
        .rti_cmd(rti_cmd), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
        .irq_ack(irq_ack), .busy(busy), .pc(pc), .status_word(status_word),
        .stk_push(stk_push), .stk_pop(stk_pop), .stk_addr(stk_addr),
        .stk_wdata(stk_wdata), .stk_rdata(stk_rdata)
    );

    always @(posedge clk) if (stk_push) mem[stk_addr] <= stk_wdata;
    assign stk_rdata = mem[stk_addr];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic write_sw(input logic [DW-1:0] v);
        sw_wr = 1'b1; sw_wdata = v;
        tick();
        sw_wr = 1'b0;
    endtask

    task automatic step();
        insn_done = 1'b1;
        tick();
        insn_done = 1'b0;
    endtask

    task automatic enter();
        insn_done = 1'b1; irq_req = 1'b1;
        tick();
        insn_done = 1'b0; irq_req = 1'b0;
        tick();
        tick();
    endtask

    task automatic leave();
        insn_done = 1'b1; rti_cmd = 1'b1;
        tick();
        insn_done = 1'b0; rti_cmd = 1'b0;
        tick();
        tick();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected <100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2**SAW; i++) mem[i] = '0;
        do_reset();
        // R1: reset state
        chk("R1 pc", pc, 0);
        chk("R1 sw", status_word, 0);
        chk("R1 addr", stk_addr, TOP);
        chk("R1 busy/ack/push/pop", {busy, irq_ack, stk_push, stk_pop}, 0);

        // Table walk: entry and return for several PCs and status words
        for (int v = 0; v < NV; v++) begin
            do_reset();
            write_sw(V_SW[v]);
            for (int s = 0; s < V_STEPS[v]; s++) step();
            chk("R2 pc after steps", pc, V_STEPS[v]);
            insn_done = 1'b1; irq_req = 1'b1;
            tick();
            insn_done = 1'b0; irq_req = 1'b0;
            chk("R4 ack high", irq_ack, 1);
            chk("R8 busy in push", busy, 1);
            chk("R5 push1 addr", stk_addr, TOP - 1);
            chk("R5 push1 data", stk_wdata, V_STEPS[v] + 1);
            tick();
            chk("R4 ack low", irq_ack, 0);
            chk("R5 push2 addr", stk_addr, TOP - 2);
            chk("R5 push2 data", stk_wdata, V_SW[v]);
            tick();
            chk("R6 busy done", busy, 0);
            chk("R6 pc handler", pc, HPC);
            chk("R6 ie cleared", status_word, V_SW[v] & 16'hFFFE);
            chk("R5 mem pc", mem[TOP-1], V_STEPS[v] + 1);
            chk("R5 mem sw", mem[TOP-2], V_SW[v]);
            step();
            chk("R2 handler step", pc, HPC + 1);
            insn_done = 1'b1; rti_cmd = 1'b1;
            tick();
            insn_done = 1'b0; rti_cmd = 1'b0;
            chk("R7 pop1", {stk_pop, stk_addr}, {1'b1, 8'(TOP - 2)});
            tick();
            chk("R7 pop2 addr", stk_addr, TOP - 1);
            chk("R7 sw restored", status_word, V_SW[v]);
            tick();
            chk("R7 pc restored", pc, V_STEPS[v] + 1);
            chk("R7 busy off", busy, 0);
            chk("R7 sp top", stk_addr, TOP);
        end

        // R3: IE clear, request ignored, pc just steps
        do_reset();
        insn_done = 1'b1; irq_req = 1'b1;
        tick();
        insn_done = 1'b0;
        chk("R3 no ack ie=0", {irq_ack, busy, stk_push}, 0);
        chk("R3 pc stepped", pc, 1);
        // R3: IE set, request without boundary ignored
        write_sw(16'h0001);
        tick();
        chk("R3 no ack no boundary", {irq_ack, busy, stk_push}, 0);
        chk("R10 sw written", status_word, 16'h0001);
        irq_req = 1'b0;

        // R6: second request held off inside handler
        enter();
        insn_done = 1'b1; irq_req = 1'b1;
        tick();
        insn_done = 1'b0;
        chk("R6 held off", {irq_ack, busy}, 0);
        chk("R6 pc steps in handler", pc, HPC + 1);
        irq_req = 1'b0;

        // R8: inputs ignored while busy
        do_reset();
        write_sw(16'h0041);
        step();
        step();
        insn_done = 1'b1; irq_req = 1'b1;
        tick();
        irq_req = 1'b0;
        sw_wr = 1'b1; sw_wdata = 16'hFFFF;
        tick();
        insn_done = 1'b0; sw_wr = 1'b0;
        tick();
        chk("R8 pc unaffected", pc, HPC);
        chk("R8 sw unaffected", status_word, 16'h0040);
        chk("R8 saved pc", mem[TOP-1], 3);

        // R9: return beats an enabled request at the same boundary
        write_sw(16'h0001);
        insn_done = 1'b1; rti_cmd = 1'b1; irq_req = 1'b1;
        tick();
        insn_done = 1'b0; rti_cmd = 1'b0; irq_req = 1'b0;
        chk("R9 no ack, popping", {irq_ack, stk_pop}, 2'b01);
        tick();
        tick();
        chk("R9 pc restored", pc, 3);
        chk("R9 sw restored", status_word, 16'h0041);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule